// File: doc/BRIEF.md
# Pin-Configured Serial Audio Receiver

This block takes a three-wire serial audio stream (bit clock, word-select clock and one data line) into the system clock domain. It rebuilds one left and one right two's-complement sample per frame and presents them as parallel 24-bit words with a one-cycle valid strobe. Four static mode pins choose how the stream is read: two pins pick the frame format, one pin picks stereo or mono, and a channel pin picks either the mono source channel or the filter rolloff. One combination of the four pins is reserved for a filter-bypass mode. The block does no filtering. It only reports the rolloff choice and the bypass condition as flags for the stages that follow it.

The three serial wires pass through a synchronizer and are sampled on each detected rising edge of the bit clock. A four-state controller then follows the word-select halves. `ST_IDLE` is the state after reset. On the first bit-clock edge it records the word-select level and moves to `ST_HUNT`. `ST_HUNT` discards the partial half that was under way at reset, and moves to `ST_COLLECT` on the first word-select change. `ST_COLLECT` counts bits inside a half:
- In the two MSB-aligned formats it captures the word at its last bit and moves to `ST_HOLD`.
- In the two LSB-aligned formats it captures the word that ended when the next word-select change arrives, and stays in `ST_COLLECT`.

`ST_HOLD` ignores the rest of the half and returns to `ST_COLLECT` on the next word-select change.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is active, and after it is released, both sample outputs read zero and `sample_valid` is low until the first frame completes.
- R2: With `fmt_sel`=00 (I2S-style), the MSB comes one bit clock after the word-select change, 24 bits are taken, and word-select low marks the left channel.
- R3: With `fmt_sel`=01 (MSB-aligned), the MSB comes on the bit clock of the word-select change, 24 bits are taken, and word-select high marks the left channel.
- R4: With `fmt_sel`=10, the last 16 bits before the word-select change form the sample. They appear in output bits 23:8 and bits 7:0 read zero. Word-select high marks the left channel.
- R5: With `fmt_sel`=11, the last 24 bits before the word-select change form the sample. Word-select high marks the left channel.
- R6: `sample_valid` pulses for exactly one clock once per frame, after the right sample is complete. The half in progress at reset produces nothing, and a right sample with no left sample before it produces no strobe.
- R7: With `mono_sel`=1, the channel picked by `chan_sel` (0 = left, 1 = right) appears on both outputs.
- R8: `slow_rolloff` is high only when `mono_sel`=0, `chan_sel`=1 and `fmt_sel` is not 11.
- R9: The code `mono_sel`=0, `chan_sel`=1, `fmt_sel`=11 drives `filter_bypass` high. The stream is then read as in R5, and the left channel is copied to both outputs.
- R10: Between strobes the sample outputs hold their values.
- R11: Data is sampled only at rising edges of the bit clock; changes on `sdata` while the bit clock is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Word-select clock |
| sdata | input | 1 | Serial data, MSB first |
| mono_sel | input | 1 | Mode pin: 1 = mono |
| chan_sel | input | 1 | Mode pin: mono channel or rolloff choice |
| fmt_sel | input | 2 | Mode pins: frame format |
| left_out | output | 24 | Left sample |
| right_out | output | 24 | Right sample |
| sample_valid | output | 1 | One-cycle strobe per completed frame |
| slow_rolloff | output | 1 | Slow-rolloff flag |
| filter_bypass | output | 1 | Filter-bypass flag |

## Verification
If the bit counter is off by one, the next strobe shows every sample shifted by one bit position, so the error appears within one frame. If the left/right polarity is wrong, the channels come out swapped on the very first strobe. If the controller leaves `ST_HUNT` too early, an extra or garbled first frame appears, or strobes come out of step with the frames, which the scoreboard reports as an unexpected item. Mono and bypass routing errors show up on the first strobe as outputs that differ from each other.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LJ   = 2'b01,
        FMT_RJ16 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_COLLECT,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        fmt_e fmt;
        logic mono;
        logic pick_right;
        logic slow;
        logic bypass;
    } mode_t;

endpackage

// File: rtl/sar_mode_decode.sv
module sar_mode_decode
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mono_pin,
    input  logic       chsel_pin,
    input  logic [1:0] fmt_pin,
    output mode_t      mode
);

    logic bypass_code;

    always_comb begin
        bypass_code     = !mono_pin && chsel_pin && (fmt_pin == 2'b11);
        mode.fmt        = fmt_e'(fmt_pin);
        mode.mono       = mono_pin || bypass_code;
        mode.pick_right = mono_pin && chsel_pin;
        mode.slow       = !mono_pin && chsel_pin && !bypass_code;
        mode.bypass     = bypass_code;
    end

    // R8
    rolloff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.slow |-> (!mono_pin && chsel_pin && fmt_pin != 2'b11));

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.bypass |-> (mode.fmt == FMT_RJ24 && mode.mono && !mode.pick_right));

endmodule

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck,
    input  logic lrck,
    input  logic sdata,
    output logic bit_stb,
    output logic bit_val,
    output logic lr_val
);

    localparam int TAP = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   bck_q;
    logic [SYNC_STAGES-1:0] lr_q;
    logic [SYNC_STAGES-1:0] dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bck_q <= '0;
            lr_q  <= '0;
            dat_q <= '0;
        end else begin
            bck_q <= {bck_q[SYNC_STAGES-1:0], bck};
            lr_q  <= {lr_q[SYNC_STAGES-2:0], lrck};
            dat_q <= {dat_q[SYNC_STAGES-2:0], sdata};
        end
    end

    assign bit_stb = bck_q[TAP] && !bck_q[TAP+1];
    assign bit_val = dat_q[TAP];
    assign lr_val  = lr_q[TAP];

    // R11
    bit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

endmodule

// File: rtl/sar_frame_fsm.sv
module sar_frame_fsm
    import sar_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic                lr_val,
    input  fmt_e                fmt,
    input  logic                mono,
    input  logic                pick_right,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output logic                frame_stb
);

    localparam int                PAD_W   = SAMPLE_W - SHORT_W;
    localparam logic [CNT_W-1:0]  END_MSB = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0]  END_I2S = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    rx_state_e           state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                lr_prev;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] shift_nx;
    logic [SAMPLE_W-1:0] rj_word;
    logic [SAMPLE_W-1:0] cap_l;
    logic                have_left;
    logic                lr_edge;
    logic                is_rj;
    logic                cur_left;
    logic [CNT_W-1:0]    end_idx;
    logic                cap_ev;
    logic                cap_left;
    logic [SAMPLE_W-1:0] cap_word;

    always_comb begin
        lr_edge  = (lr_val != lr_prev);
        is_rj    = fmt[1];
        cur_left = (fmt == FMT_I2S) ? !lr_val : lr_val;
        end_idx  = (fmt == FMT_I2S) ? END_I2S : END_MSB;
        shift_nx = {shreg[SAMPLE_W-2:0], bit_val};
        rj_word  = (fmt == FMT_RJ16) ? {shreg[SHORT_W-1:0], {PAD_W{1'b0}}} : shreg;
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cap_ev   = 1'b0;
        cap_left = 1'b0;
        cap_word = '0;
        if (bit_stb) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_HUNT;
                ST_HUNT: begin
                    if (lr_edge) begin
                        state_d = ST_COLLECT;
                        cnt_d   = CNT_ONE;
                    end
                end
                ST_COLLECT: begin
                    if (lr_edge) begin
                        cnt_d = CNT_ONE;
                        if (is_rj) begin
                            cap_ev   = 1'b1;
                            cap_left = !cur_left;
                            cap_word = rj_word;
                        end
                    end else begin
                        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
                        if (!is_rj && cnt_q == end_idx) begin
                            cap_ev   = 1'b1;
                            cap_left = cur_left;
                            cap_word = shift_nx;
                            state_d  = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (lr_edge) begin
                        state_d = ST_COLLECT;
                        cnt_d   = CNT_ONE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lr_prev <= 1'b0;
            shreg   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (bit_stb) begin
                lr_prev <= lr_val;
                shreg   <= shift_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_l     <= '0;
            have_left <= 1'b0;
            left_q    <= '0;
            right_q   <= '0;
            frame_stb <= 1'b0;
        end else begin
            frame_stb <= 1'b0;
            if (cap_ev) begin
                if (cap_left) begin
                    cap_l     <= cap_word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    frame_stb <= 1'b1;
                    have_left <= 1'b0;
                    if (mono) begin
                        left_q  <= pick_right ? cap_word : cap_l;
                        right_q <= pick_right ? cap_word : cap_l;
                    end else begin
                        left_q  <= cap_l;
                        right_q <= cap_word;
                    end
                end
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> ($stable(left_q) && $stable(right_q)));

    // R6
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_HUNT) |=> !frame_stb);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bck,
    input  logic                lrck,
    input  logic                sdata,
    input  logic                mono_sel,
    input  logic                chan_sel,
    input  logic [1:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid,
    output logic                slow_rolloff,
    output logic                filter_bypass
);

    mode_t mode;
    logic  bit_stb;
    logic  bit_val;
    logic  lr_val;

    sar_mode_decode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mono_pin  (mono_sel),
        .chsel_pin (chan_sel),
        .fmt_pin   (fmt_sel),
        .mode      (mode)
    );

    sar_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bck     (bck),
        .lrck    (lrck),
        .sdata   (sdata),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .lr_val  (lr_val)
    );

    sar_frame_fsm #(
        .SAMPLE_W (SAMPLE_W),
        .SHORT_W  (SHORT_W),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .lr_val     (lr_val),
        .fmt        (mode.fmt),
        .mono       (mode.mono),
        .pick_right (mode.pick_right),
        .left_q     (left_out),
        .right_q    (right_out),
        .frame_stb  (sample_valid)
    );

    assign slow_rolloff  = mode.slow;
    assign filter_bypass = mode.bypass;

    // R7
    mono_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && mode.mono) |-> (left_out == right_out));

endmodule

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic        mono_sel = 1'b0;
    logic        chan_sel = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_out, right_out;
    logic        sample_valid, slow_rolloff, filter_bypass;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [47:0] exp_q[$];
    logic [47:0] last_exp = '0;
    string       cur_req = "R2";

    always #2.5 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .sdata(sdata),
        .mono_sel(mono_sel), .chan_sel(chan_sel), .fmt_sel(fmt_sel),
        .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid),
        .slow_rolloff(slow_rolloff), .filter_bypass(filter_bypass)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every strobe (R6 counts unexpected strobes)
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            if (exp_q.size() == 0) begin
                check("R6", {left_out, right_out}, 48'hDEAD_DEAD_DEAD);
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                check(cur_req, {left_out, right_out}, e);
            end
        end
    end

    function automatic logic bit_at(input logic [1:0] f, input logic [23:0] w, input int s);
        case (f)
            2'b00:   return (s >= 1 && s <= 24) ? w[24 - s] : 1'b1;
            2'b01:   return (s <= 23) ? w[23 - s] : 1'b1;
            2'b10:   return (s >= 16) ? w[39 - s] : 1'b1;
            default: return (s >= 8) ? w[31 - s] : 1'b1;
        endcase
    endfunction

    task automatic send_half(input logic lr, input logic [23:0] w, input bit glitch);
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            bck = 1'b0;
            lrck = lr;
            sdata = bit_at(fmt_sel, w, s);
            repeat (4) @(negedge clk);
            bck = 1'b1;
            repeat (2) @(negedge clk);
            if (glitch) sdata = ~sdata;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic run_block(input logic m, input logic c, input logic [1:0] f,
                             input string req, input bit glitch);
        logic lvl_left;
        logic [23:0] l, r, le, re;
        mono_sel = m; chan_sel = c; fmt_sel = f; cur_req = req;
        lvl_left = (f == 2'b00) ? 1'b0 : 1'b1;
        bck = 1'b0; lrck = ~lvl_left; sdata = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", {left_out, right_out, 23'b0, sample_valid}, 72'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {left_out, right_out, 23'b0, sample_valid}, 72'h0);
        // R8 and R9: static flags
        n_checks++;
        if (slow_rolloff !== (!m && c && f != 2'b11)) begin
            n_fail++;
            $display("FAIL R8: actual %b expected %b", slow_rolloff, (!m && c && f != 2'b11));
        end
        n_checks++;
        if (filter_bypass !== (!m && c && f == 2'b11)) begin
            n_fail++;
            $display("FAIL R9: actual %b expected %b", filter_bypass, (!m && c && f == 2'b11));
        end
        send_half(~lvl_left, 24'h5A5A5A, 1'b0);  // partial-half guard (R6)
        for (int i = 0; i < 4; i++) begin
            case (i)
                0: begin l = 24'h800000; r = 24'h7FFFFF; end
                1: begin l = 24'hFFFFFF; r = 24'h000000; end
                2: begin l = 24'h123456; r = 24'hABCDEF; end
                default: begin l = 24'hC3A501 ^ {8'(i), 16'h0}; r = 24'h0F1E2D; end
            endcase
            le = (f == 2'b10) ? {l[23:8], 8'h00} : l;
            re = (f == 2'b10) ? {r[23:8], 8'h00} : r;
            if (m && c)               last_exp = {re, re};
            else if (m || (c && f == 2'b11)) last_exp = {le, le};
            else                      last_exp = {le, re};
            exp_q.push_back(last_exp);
            send_half(lvl_left, l, glitch);
            send_half(~lvl_left, r, glitch);
        end
        send_half(lvl_left, 24'h000000, 1'b0);
        repeat (20) @(negedge clk);
        // R6: every expected frame strobed exactly once
        check("R6", 48'(exp_q.size()), 48'h0);
        exp_q.delete();
        // R10: outputs hold the last frame
        check("R10", {left_out, right_out}, last_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        run_block(1'b0, 1'b0, 2'b00, "R2", 1'b0);
        run_block(1'b0, 1'b0, 2'b01, "R3", 1'b0);
        run_block(1'b0, 1'b0, 2'b10, "R4", 1'b0);
        run_block(1'b0, 1'b0, 2'b11, "R5", 1'b0);
        run_block(1'b0, 1'b1, 2'b01, "R8", 1'b0);
        run_block(1'b1, 1'b0, 2'b00, "R7", 1'b0);
        run_block(1'b1, 1'b1, 2'b11, "R7", 1'b0);
        run_block(1'b0, 1'b1, 2'b11, "R9", 1'b0);
        run_block(1'b0, 1'b0, 2'b01, "R11", 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule